// File: doc/BRIEF.md
# Operate Microinstruction Execution Unit

This block carries out the register-only operate instructions of a 12-bit accumulator machine. It takes an instruction word together with the current accumulator, link bit, multiplier-quotient register, front-panel switch word and a user-mode flag. It returns the new accumulator, link and MQ values, plus three one-bit requests: skip the next instruction, halt the processor, or raise a user trap. Words whose top three bits are not all ones are not operate instructions. For those words, the register values pass through unchanged and no request is raised.

A single instruction word can switch on several micro-operations at once, and they are applied in a fixed order. The first family works on the 13-bit link:accumulator pair: clear, then complement, then increment, then rotate or swap. The second family tests the accumulator and link to produce a skip request whose sense one bit can invert. In this family, the switch-read and halt operations are privileged and become a trap when the processor is in user mode. The third family moves data between the accumulator and MQ.

The result either leaves through one register stage (the default) or, when the `REGISTERED` parameter is 0, appears in the same cycle. `in_valid` marks the words to be executed and is carried to `out_valid`. The surrounding sequencer writes the returned values back into its own registers and acts on the request bits.

Top module: `opr_micro_unit`

## Requirements
- R1: An instruction whose bits 11:9 are not 7 passes the accumulator, link and MQ through unchanged and raises no skip, halt or trap, whatever the user-mode flag says.
- R2: When bit 8 is 0 (family one), bit 7 clears AC and bit 6 clears the link. Bit 5 then complements AC and bit 4 complements the link, so clear plus complement gives all ones.
- R3: In family one, bit 0 adds one to the 13-bit link:AC value after the clear and complement steps and before the rotate step, so a carry out of AC toggles the link.
- R4: In family one, bits 3:1 select the last step on link:AC. Code 2 rotates left by 1 and code 3 rotates left by 2. Code 4 rotates right by 1 and code 5 rotates right by 2. Code 1 swaps the two 6-bit halves of AC and keeps the link. Codes 0, 6 and 7 leave the value as it is.
- R5: When bit 8 is 1 and bit 0 is 0 (family two), the test is (bit 6 and AC bit 11) or (bit 5 and AC equal to zero) or (bit 4 and link set). The test uses the AC value before any clear. A skip is requested when the test differs from bit 3, so bit 3 alone always skips. Family two never changes the link or MQ.
- R6: In family two, bit 7 clears AC before bit 2 ORs in the switches, so clear plus switch-read loads exactly the switch word. Outside user mode, bit 1 requests a halt.
- R7: In family two in user mode, bit 2 and bit 1 each raise the user trap instead. AC takes no switch bits and no halt is requested.
- R8: When bit 8 is 1 and bit 0 is 1 (family three), bit 7 clears AC first. Then the bits 6:4 code acts: code 1 copies AC into MQ, code 2 ORs MQ into AC, and codes 4 and 5 load AC from MQ. When bits 7:4 equal binary 1110, MQ ends at zero. The link is never changed.
- R9: In the registered build, the results and `out_valid` appear one clock after the inputs. While `rst_n` is low at a clock edge, every output becomes zero. A cycle with `in_valid` low produces no skip, halt or trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the instruction word as one to execute |
| instr | input | 12 | Instruction word |
| ac_in | input | 12 | Current accumulator |
| link_in | input | 1 | Current link bit |
| mq_in | input | 12 | Current MQ register |
| switches | input | 12 | Front-panel switch word |
| user_mode | input | 1 | Processor is running in user mode |
| out_valid | output | 1 | Results below belong to an executed word |
| ac_out | output | 12 | New accumulator |
| link_out | output | 1 | New link bit |
| mq_out | output | 12 | New MQ register |
| skip_req | output | 1 | Skip the next instruction |
| halt_req | output | 1 | Stop the processor |
| user_trap | output | 1 | A privileged operation was tried in user mode |

## Verification
Every micro-operation ends in an output register, so a wrong step order or a wrong rotate code shows in `ac_out` or `link_out` in the next cycle. Corrupted skip-test state or a swapped privilege path shows just as quickly, as a wrong `skip_req`, `halt_req` or `user_trap`. Nothing is kept from one instruction to the next. An error therefore never hides until later: it affects only the result of the word that triggered it, one cycle after that word is presented.

// File: rtl/opr_pkg.sv
// Shared definitions for the operate microinstruction unit.
// Assumes a 12-bit instruction word. The field positions are fixed by the
// instruction format and do not scale with the data width.
package opr_pkg;

    localparam int IW       = 12;
    localparam int OPC_HI   = 11;
    localparam int OPC_LO   = 9;
    localparam int GRP_BIT  = 8;
    localparam int SUB_BIT  = 0;

    typedef enum logic [1:0] {
        GRP_NONE  = 2'd0,
        GRP_ONE   = 2'd1,
        GRP_TWO   = 2'd2,
        GRP_THREE = 2'd3
    } grp_e;

    typedef enum logic [2:0] {
        SH_NONE = 3'd0,
        SH_SWAP = 3'd1,
        SH_RL1  = 3'd2,
        SH_RL2  = 3'd3,
        SH_RR1  = 3'd4,
        SH_RR2  = 3'd5,
        SH_RSV6 = 3'd6,
        SH_RSV7 = 3'd7
    } shift_e;

    typedef enum logic [2:0] {
        MQ_NOP     = 3'd0,
        MQ_LOAD    = 3'd1,
        MQ_MERGE   = 3'd2,
        MQ_RSV3    = 3'd3,
        MQ_FETCH   = 3'd4,
        MQ_FETCH_B = 3'd5,
        MQ_RSV6    = 3'd6,
        MQ_RSV7    = 3'd7
    } mqop_e;

    // Classify an instruction word into one of the three operate families.
    function automatic grp_e decode_group(input logic [IW-1:0] ins);
        if (ins[OPC_HI:OPC_LO] != 3'b111)
            return GRP_NONE;
        else if (!ins[GRP_BIT])
            return GRP_ONE;
        else if (!ins[SUB_BIT])
            return GRP_TWO;
        else
            return GRP_THREE;
    endfunction

endpackage

// File: rtl/opr_grp1.sv
// Family one: clear, complement, increment, then rotate or swap on link:AC.
// Assumes an even data width W of at least 4; the swap exchanges W/2 halves.
module opr_grp1
    import opr_pkg::*;
#(
    parameter int W = 12
) (
    input  logic [7:0]   ctl,      // instruction bits 7..0
    input  logic [W-1:0] ac_i,
    input  logic         link_i,
    output logic [W-1:0] ac_o,
    output logic         link_o
);
    localparam int H = W / 2;

    logic [W-1:0] ac_clr, ac_cmp;
    logic         l_clr, l_cmp;
    logic [W:0]   inc_v;
    logic [W:0]   rot_v;
    shift_e       sh_sel;

    // Clear and complement stages, applied in that order.
    always_comb begin
        ac_clr = ctl[7] ? '0 : ac_i;
        l_clr  = ctl[6] ? 1'b0 : link_i;
        ac_cmp = ctl[5] ? ~ac_clr : ac_clr;
        l_cmp  = ctl[4] ? ~l_clr : l_clr;
    end

    // Increment of the 13-bit combined value; a carry out of AC toggles the link.
    always_comb begin
        inc_v = {l_cmp, ac_cmp} + {{W{1'b0}}, ctl[0]};
    end

    // Final rotate or half swap selected by bits 3:1.
    always_comb begin
        sh_sel = shift_e'(ctl[3:1]);
        case (sh_sel)
            SH_SWAP: rot_v = {inc_v[W], inc_v[H-1:0], inc_v[W-1:H]};
            SH_RL1:  rot_v = {inc_v[W-1:0], inc_v[W]};
            SH_RL2:  rot_v = {inc_v[W-2:0], inc_v[W:W-1]};
            SH_RR1:  rot_v = {inc_v[0], inc_v[W:1]};
            SH_RR2:  rot_v = {inc_v[1:0], inc_v[W:2]};
            default: rot_v = inc_v;
        endcase
    end

    // Split the result back into link and accumulator.
    always_comb begin
        link_o = rot_v[W];
        ac_o   = rot_v[W-1:0];
    end

endmodule

// File: rtl/opr_grp2.sv
// Family two: conditional skip, AC clear, switch read and halt.
// The skip test uses the incoming AC. In user mode, switch read and halt
// are turned into a trap request.
module opr_grp2
    import opr_pkg::*;
#(
    parameter int W = 12
) (
    input  logic [7:0]   ctl,      // instruction bits 7..0
    input  logic [W-1:0] ac_i,
    input  logic         link_i,
    input  logic [W-1:0] sw_i,
    input  logic         user_i,
    output logic [W-1:0] ac_o,
    output logic         skip_o,
    output logic         halt_o,
    output logic         trap_o
);
    logic         test_hit;
    logic [W-1:0] ac_clr;

    // Evaluate the combined skip test and apply the sense bit.
    always_comb begin
        test_hit = (ctl[6] && ac_i[W-1]) ||
                   (ctl[5] && (ac_i == '0)) ||
                   (ctl[4] && link_i);
        skip_o   = test_hit ^ ctl[3];
    end

    // Clear first, then the switch OR when privileged operations are allowed.
    always_comb begin
        ac_clr = ctl[7] ? '0 : ac_i;
        ac_o   = (ctl[2] && !user_i) ? (ac_clr | sw_i) : ac_clr;
    end

    // Route the privileged bits to a halt or to the user trap.
    always_comb begin
        halt_o = ctl[1] && !user_i;
        trap_o = (ctl[2] || ctl[1]) && user_i;
    end

endmodule

// File: rtl/opr_grp3.sv
// Family three: AC clear followed by transfers between AC and MQ.
// A clear combined with code 6 also zeroes MQ.
module opr_grp3
    import opr_pkg::*;
#(
    parameter int W = 12
) (
    input  logic [7:0]   ctl,      // instruction bits 7..0
    input  logic [W-1:0] ac_i,
    input  logic [W-1:0] mq_i,
    output logic [W-1:0] ac_o,
    output logic [W-1:0] mq_o
);
    logic [W-1:0] ac_clr;
    logic [W-1:0] mq_mid;
    mqop_e        op;

    // Clear stage ahead of every transfer.
    always_comb begin
        ac_clr = ctl[7] ? '0 : ac_i;
    end

    // Transfer selected by bits 6:4.
    always_comb begin
        op     = mqop_e'(ctl[6:4]);
        ac_o   = ac_clr;
        mq_mid = mq_i;
        case (op)
            MQ_LOAD:    mq_mid = ac_clr;
            MQ_MERGE:   ac_o   = ac_clr | mq_i;
            MQ_FETCH,
            MQ_FETCH_B: ac_o   = mq_i;
            default:    ;
        endcase
    end

    // MQ zeroing for the clear-with-code-6 combination.
    always_comb begin
        mq_o = (ctl[7:4] == 4'b1110) ? '0 : mq_mid;
    end

endmodule

// File: rtl/opr_micro_unit.sv
// Top of the operate unit. Decodes the family, picks that family's
// result and optionally registers it.
// Assumes the caller writes back ac_out, link_out and mq_out and acts on
// the request bits only when out_valid is set.
module opr_micro_unit
    import opr_pkg::*;
#(
    parameter int W          = 12,
    parameter bit REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [11:0]  instr,
    input  logic [W-1:0] ac_in,
    input  logic         link_in,
    input  logic [W-1:0] mq_in,
    input  logic [W-1:0] switches,
    input  logic         user_mode,
    output logic         out_valid,
    output logic [W-1:0] ac_out,
    output logic         link_out,
    output logic [W-1:0] mq_out,
    output logic         skip_req,
    output logic         halt_req,
    output logic         user_trap
);
    grp_e         grp;
    logic [W-1:0] g1_ac, g2_ac, g3_ac, g3_mq;
    logic         g1_link, g2_skip, g2_halt, g2_trap;

    logic [W-1:0] nx_ac, nx_mq;
    logic         nx_link, nx_skip, nx_halt, nx_trap;

    // Family classification of the incoming word.
    always_comb begin
        grp = decode_group(instr);
    end

    opr_grp1 #(.W(W)) u_grp1 (
        .ctl    (instr[7:0]),
        .ac_i   (ac_in),
        .link_i (link_in),
        .ac_o   (g1_ac),
        .link_o (g1_link)
    );

    opr_grp2 #(.W(W)) u_grp2 (
        .ctl    (instr[7:0]),
        .ac_i   (ac_in),
        .link_i (link_in),
        .sw_i   (switches),
        .user_i (user_mode),
        .ac_o   (g2_ac),
        .skip_o (g2_skip),
        .halt_o (g2_halt),
        .trap_o (g2_trap)
    );

    opr_grp3 #(.W(W)) u_grp3 (
        .ctl  (instr[7:0]),
        .ac_i (ac_in),
        .mq_i (mq_in),
        .ac_o (g3_ac),
        .mq_o (g3_mq)
    );

    // Select the active family's result; requests only for valid words.
    always_comb begin
        nx_ac   = ac_in;
        nx_link = link_in;
        nx_mq   = mq_in;
        nx_skip = 1'b0;
        nx_halt = 1'b0;
        nx_trap = 1'b0;
        case (grp)
            GRP_ONE: begin
                nx_ac   = g1_ac;
                nx_link = g1_link;
            end
            GRP_TWO: begin
                nx_ac   = g2_ac;
                nx_skip = g2_skip && in_valid;
                nx_halt = g2_halt && in_valid;
                nx_trap = g2_trap && in_valid;
            end
            GRP_THREE: begin
                nx_ac = g3_ac;
                nx_mq = g3_mq;
            end
            default: ;
        endcase
    end

    generate
        if (REGISTERED) begin : g_reg
            // Single output stage with synchronous active-low reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid <= 1'b0;
                    ac_out    <= '0;
                    link_out  <= 1'b0;
                    mq_out    <= '0;
                    skip_req  <= 1'b0;
                    halt_req  <= 1'b0;
                    user_trap <= 1'b0;
                end else begin
                    out_valid <= in_valid;
                    ac_out    <= nx_ac;
                    link_out  <= nx_link;
                    mq_out    <= nx_mq;
                    skip_req  <= nx_skip;
                    halt_req  <= nx_halt;
                    user_trap <= nx_trap;
                end
            end
        end else begin : g_comb
            // Direct combinational outputs.
            always_comb begin
                out_valid = in_valid;
                ac_out    = nx_ac;
                link_out  = nx_link;
                mq_out    = nx_mq;
                skip_req  = nx_skip;
                halt_req  = nx_halt;
                user_trap = nx_trap;
            end
        end
    endgenerate

endmodule

// File: rtl/opr_micro_unit_chk.sv
// Port-level properties for the registered build of the operate unit.
// Attached to every instance of the top module by the bind below.
module opr_micro_unit_chk #(
    parameter int W          = 12,
    parameter bit REGISTERED = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [11:0]  instr,
    input logic [W-1:0] ac_in,
    input logic         link_in,
    input logic [W-1:0] mq_in,
    input logic         user_mode,
    input logic         out_valid,
    input logic [W-1:0] ac_out,
    input logic         link_out,
    input logic [W-1:0] mq_out,
    input logic         skip_req,
    input logic         halt_req,
    input logic         user_trap
);
    generate
        if (REGISTERED) begin : g_props
            a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && instr[11:9] != 3'b111) |=>
                    (ac_out == $past(ac_in) && link_out == $past(link_in) &&
                     mq_out == $past(mq_in) && !skip_req && !halt_req && !user_trap));

            a_r5_forced_skip: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && instr[11:8] == 4'hF && !instr[0] &&
                 instr[3] && instr[6:4] == 3'b000) |=> skip_req);

            a_r6_halt_request: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && instr[11:8] == 4'hF && !instr[0] &&
                 instr[1] && !user_mode) |=> halt_req);

            a_r7_user_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && user_mode) |=> !halt_req);

            a_r7_trap_needs_user: assert property (@(posedge clk) disable iff (!rst_n)
                (!user_mode) |=> !user_trap);

            a_r8_mq_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && instr[11:8] == 4'hF && instr[0] &&
                 instr[7:4] == 4'b1110) |=> (mq_out == '0 && ac_out == '0 &&
                                             link_out == $past(link_in)));

            a_r9_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (out_valid == $past(in_valid)));

            a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                (!in_valid) |=> (!skip_req && !halt_req && !user_trap));
        end
    endgenerate

endmodule

bind opr_micro_unit opr_micro_unit_chk #(.W(W), .REGISTERED(REGISTERED)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .ac_in     (ac_in),
    .link_in   (link_in),
    .mq_in     (mq_in),
    .user_mode (user_mode),
    .out_valid (out_valid),
    .ac_out    (ac_out),
    .link_out  (link_out),
    .mq_out    (mq_out),
    .skip_req  (skip_req),
    .halt_req  (halt_req),
    .user_trap (user_trap)
);

// File: tb/opr_micro_unit_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed
// reset and validity tests.
module opr_micro_unit_bench;

    typedef struct packed {
        logic [11:0] ins;
        logic [11:0] ac;
        logic        l;
        logic [11:0] mq;
        logic [11:0] sw;
        logic        u;
        logic [11:0] eac;
        logic        el;
        logic [11:0] emq;
        logic        esk;
        logic        ehl;
        logic        etr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VEC [NV] = '{
        // R1: words outside the operate space pass through
        '{12'o1234, 12'o5555, 1'b1, 12'o0123, 12'o0000, 1'b0, 12'o5555, 1'b1, 12'o0123, 1'b0, 1'b0, 1'b0, 4'd1},
        '{12'o6001, 12'o0707, 1'b0, 12'o0000, 12'o7777, 1'b1, 12'o0707, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd1},
        // R2: clear and complement ordering
        '{12'o7300, 12'o1234, 1'b1, 12'o0000, 12'o0000, 1'b0, 12'o0000, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd2},
        '{12'o7240, 12'o1234, 1'b0, 12'o0000, 12'o0000, 1'b0, 12'o7777, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd2},
        '{12'o7020, 12'o4321, 1'b0, 12'o0000, 12'o0000, 1'b0, 12'o4321, 1'b1, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd2},
        // R3: increment on link:AC
        '{12'o7001, 12'o7777, 1'b0, 12'o0000, 12'o0000, 1'b0, 12'o0000, 1'b1, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd3},
        '{12'o7001, 12'o7777, 1'b1, 12'o0000, 12'o0000, 1'b0, 12'o0000, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd3},
        '{12'o7041, 12'o0005, 1'b0, 12'o0000, 12'o0000, 1'b0, 12'o7773, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd3},
        '{12'o7205, 12'o1234, 1'b1, 12'o0000, 12'o0000, 1'b0, 12'o0003, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd3},
        // R4: rotates and swap
        '{12'o7004, 12'o4001, 1'b0, 12'o0000, 12'o0000, 1'b0, 12'o0002, 1'b1, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd4},
        '{12'o7006, 12'o4001, 1'b1, 12'o0000, 12'o0000, 1'b0, 12'o0007, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd4},
        '{12'o7010, 12'o0003, 1'b0, 12'o0000, 12'o0000, 1'b0, 12'o0001, 1'b1, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd4},
        '{12'o7012, 12'o0003, 1'b0, 12'o0000, 12'o0000, 1'b0, 12'o4000, 1'b1, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd4},
        '{12'o7002, 12'o1234, 1'b1, 12'o0000, 12'o0000, 1'b0, 12'o3412, 1'b1, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd4},
        '{12'o7014, 12'o1234, 1'b0, 12'o0000, 12'o0000, 1'b0, 12'o1234, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd4},
        // R5: skip test and its sense
        '{12'o7500, 12'o4000, 1'b0, 12'o0000, 12'o0000, 1'b0, 12'o4000, 1'b0, 12'o0000, 1'b1, 1'b0, 1'b0, 4'd5},
        '{12'o7500, 12'o3777, 1'b0, 12'o0000, 12'o0000, 1'b0, 12'o3777, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd5},
        '{12'o7440, 12'o0000, 1'b0, 12'o0000, 12'o0000, 1'b0, 12'o0000, 1'b0, 12'o0000, 1'b1, 1'b0, 1'b0, 4'd5},
        '{12'o7420, 12'o0001, 1'b1, 12'o0000, 12'o0000, 1'b0, 12'o0001, 1'b1, 12'o0000, 1'b1, 1'b0, 1'b0, 4'd5},
        '{12'o7510, 12'o4000, 1'b0, 12'o0000, 12'o0000, 1'b0, 12'o4000, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd5},
        '{12'o7410, 12'o0123, 1'b0, 12'o0000, 12'o0000, 1'b0, 12'o0123, 1'b0, 12'o0000, 1'b1, 1'b0, 1'b0, 4'd5},
        '{12'o7450, 12'o0000, 1'b0, 12'o0000, 12'o0000, 1'b0, 12'o0000, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd5},
        '{12'o7640, 12'o0000, 1'b0, 12'o0000, 12'o0000, 1'b0, 12'o0000, 1'b0, 12'o0000, 1'b1, 1'b0, 1'b0, 4'd5},
        '{12'o7640, 12'o0005, 1'b0, 12'o0000, 12'o0000, 1'b0, 12'o0000, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd5},
        // R6: switch read and halt outside user mode
        '{12'o7404, 12'o0101, 1'b0, 12'o0000, 12'o1010, 1'b0, 12'o1111, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd6},
        '{12'o7604, 12'o7777, 1'b0, 12'o0000, 12'o1234, 1'b0, 12'o1234, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd6},
        '{12'o7402, 12'o0042, 1'b0, 12'o0000, 12'o0000, 1'b0, 12'o0042, 1'b0, 12'o0000, 1'b0, 1'b1, 1'b0, 4'd6},
        // R7: privileged bits in user mode trap instead
        '{12'o7402, 12'o0042, 1'b0, 12'o0000, 12'o0000, 1'b1, 12'o0042, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b1, 4'd7},
        '{12'o7404, 12'o2222, 1'b0, 12'o0000, 12'o5555, 1'b1, 12'o2222, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b1, 4'd7},
        // R8: MQ transfers
        '{12'o7421, 12'o1234, 1'b0, 12'o0000, 12'o0000, 1'b0, 12'o1234, 1'b0, 12'o1234, 1'b0, 1'b0, 1'b0, 4'd8},
        '{12'o7441, 12'o1200, 1'b1, 12'o0034, 12'o0000, 1'b0, 12'o1234, 1'b1, 12'o0034, 1'b0, 1'b0, 1'b0, 4'd8},
        '{12'o7501, 12'o1111, 1'b0, 12'o2345, 12'o0000, 1'b0, 12'o2345, 1'b0, 12'o2345, 1'b0, 1'b0, 1'b0, 4'd8},
        '{12'o7521, 12'o1111, 1'b0, 12'o2345, 12'o0000, 1'b0, 12'o2345, 1'b0, 12'o2345, 1'b0, 1'b0, 1'b0, 4'd8},
        '{12'o7621, 12'o1234, 1'b0, 12'o4444, 12'o0000, 1'b0, 12'o0000, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd8},
        '{12'o7741, 12'o1234, 1'b1, 12'o4321, 12'o0000, 1'b0, 12'o0000, 1'b1, 12'o0000, 1'b0, 1'b0, 1'b0, 4'd8},
        '{12'o7601, 12'o1234, 1'b0, 12'o0005, 12'o0000, 1'b0, 12'o0000, 1'b0, 12'o0005, 1'b0, 1'b0, 1'b0, 4'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [11:0] instr, ac_in, mq_in, switches;
    logic        link_in, user_mode;
    logic        out_valid, link_out, skip_req, halt_req, user_trap;
    logic [11:0] ac_out, mq_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    opr_micro_unit u_opr_micro_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .instr     (instr),
        .ac_in     (ac_in),
        .link_in   (link_in),
        .mq_in     (mq_in),
        .switches  (switches),
        .user_mode (user_mode),
        .out_valid (out_valid),
        .ac_out    (ac_out),
        .link_out  (link_out),
        .mq_out    (mq_out),
        .skip_req  (skip_req),
        .halt_req  (halt_req),
        .user_trap (user_trap)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0o expected %0o", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        rst_n     = 1'b0;
        in_valid  = 1'b1;
        instr     = 12'o7402;
        ac_in     = 12'o7777;
        link_in   = 1'b1;
        mq_in     = 12'o7777;
        switches  = 12'o0000;
        user_mode = 1'b0;
        repeat (3) @(negedge clk);

        // R9: outputs held at zero while in reset, even with a halt word applied
        check("R9 reset out_valid", 64'(out_valid), 64'd0);
        check("R9 reset ac/link/mq", 64'({ac_out, link_out, mq_out}), 64'd0);
        check("R9 reset requests", 64'({skip_req, halt_req, user_trap}), 64'd0);

        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            instr     = VEC[i].ins;
            ac_in     = VEC[i].ac;
            link_in   = VEC[i].l;
            mq_in     = VEC[i].mq;
            switches  = VEC[i].sw;
            user_mode = VEC[i].u;
            in_valid  = 1'b1;
            @(negedge clk);
            check($sformatf("R%0d vec %0d all outputs", VEC[i].req, i),
                  64'({out_valid, ac_out, link_out, mq_out, skip_req, halt_req, user_trap}),
                  64'({1'b1, VEC[i].eac, VEC[i].el, VEC[i].emq, VEC[i].esk, VEC[i].ehl, VEC[i].etr}));
        end

        // R9: an invalid halt word gives no request and a low out_valid
        in_valid  = 1'b0;
        instr     = 12'o7402;
        user_mode = 1'b0;
        @(negedge clk);
        check("R9 idle out_valid", 64'(out_valid), 64'd0);
        check("R9 idle no halt", 64'({skip_req, halt_req, user_trap}), 64'd0);

        // R7: switch read plus halt together in user mode trap; no switch bits, no halt
        in_valid  = 1'b1;
        instr     = 12'o7406;
        ac_in     = 12'o0000;
        switches  = 12'o7777;
        user_mode = 1'b1;
        @(negedge clk);
        check("R7 combined privileged", 64'({ac_out, halt_req, user_trap}), 64'({12'o0000, 1'b0, 1'b1}));

        // R9: reset asserted mid-run clears the registered results next edge
        instr     = 12'o7410;
        user_mode = 1'b0;
        rst_n     = 1'b0;
        @(negedge clk);
        check("R9 mid-run reset", 64'({out_valid, skip_req, ac_out}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 recovery skip", 64'({out_valid, skip_req}), 64'({1'b1, 1'b1}));

        finish_run();
    end

endmodule